// File: doc/BRIEF.md
# Mains-Synchronized Thyristor Gate Pulse Generator

This block produces the gate-firing pulse for a half-wave phase-controlled rectifier. It receives a digital square wave that is high while the mains is in its positive half cycle. Each time that wave rises, the block waits a programmable number of clock ticks. That wait sets the firing angle. When the wait ends, the block drives a gate pulse of programmable width. The result is exactly one pulse per positive half cycle.

The sync wave is first brought into the clock domain. It is then filtered so that a high level must persist for a minimum time before it counts. This rejects chatter near the zero crossing. The delay count is sampled when the filtered rising edge occurs, and it is clamped to the half-period count. The pulse width is sampled when the delay expires.

The pulse is cut short if the sync level drops, so the gate is never driven in the negative half cycle. A low enable input idles both stages. All pins are plain control and status signals, so there is no handshake and no back-pressure.

Top module: `firing_pulse_gen`

## Requirements
- R1: While reset is asserted, and directly after it is released, `gate` and `delay_busy` are low.
- R2: Each rising edge of `sync_in` is recognized only after `sync_in` has been sampled high on FILT_LEN consecutive clock edges. A high run of fewer samples produces no busy flag and no gate pulse.
- R3: Let edge k be the first clock edge that samples `sync_in` high. With an effective delay N of 0, `gate` rises at edge k+FILT_LEN+2, and `delay_busy` stays low.
- R4: With an effective delay N greater than 0, `delay_busy` is high from edge k+FILT_LEN+2 for exactly N cycles. It falls at the same edge at which `gate` rises, which is edge k+FILT_LEN+2+N.
- R5: An `angle` value above HALF_CNT is clamped, so the effective delay is HALF_CNT.
- R6: `gate` stays high for `width` cycles. A `width` of 0 gives a one-cycle pulse.
- R7: If `sync_in` goes low while `gate` is high, `gate` is low no later than the fourth clock edge that samples `sync_in` low.
- R8: At most one pulse occurs per positive half cycle. A change to `angle` after the filtered rising edge has no effect until the next rising edge.
- R9: While `enable` is low, `gate` and `delay_busy` are low. A delay that was cleared by `enable` going low does not fire later in the same half cycle.
- R10: If `sync_in` goes low before the delay expires, the delay is abandoned and no pulse is produced in that half cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | High to allow firing; low idles the block and holds the gate low |
| sync_in | input | 1 | Asynchronous mains polarity square wave, high in the positive half cycle |
| angle | input | CNT_W | Firing delay in clock ticks, sampled at each filtered rising edge |
| width | input | CNT_W | Gate pulse width in clock ticks, sampled when the delay ends |
| gate | output | 1 | Gate firing pulse |
| delay_busy | output | 1 | High while the firing delay is counting |

## Verification
The hardest situations to reach are those where the half cycle ends early, or the block is disabled, while a delay or a pulse is still in flight. Each of these needs the sync level or the enable to change at a chosen cycle inside a count that began many cycles earlier. The bench starts each half cycle with a known delay and width. It then drops `sync_in` or `enable` a fixed number of cycles later. After that it watches the outputs for the rest of the window, to confirm that no late pulse appears. The pulse-truncation case uses a width much larger than the remaining high time, so the cut comes from the sync input and not from the width count.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
  // Filtered view of the mains polarity input
  typedef struct packed {
    logic level;  // filtered positive-half-cycle level
    logic rise;   // one-cycle strobe when level becomes high
  } sync_ev_t;
endpackage

// File: rtl/fpg_sync_filter.sv
module fpg_sync_filter
  import fpg_pkg::*;
#(
  parameter int FILT_LEN = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     raw,
  output sync_ev_t ev
);
  localparam int FW = $clog2(FILT_LEN + 1);
  localparam logic [FW-1:0] LAST = FW'(FILT_LEN - 1);

  logic          meta, stable;
  logic [FW-1:0] run;
  logic          lvl, rise_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta   <= 1'b0;
      stable <= 1'b0;
    end else begin
      meta   <= raw;
      stable <= meta;
    end
  end

  // Level is accepted only after FILT_LEN consecutive high samples
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= '0;
      lvl    <= 1'b0;
      rise_q <= 1'b0;
    end else if (!stable) begin
      run    <= '0;
      lvl    <= 1'b0;
      rise_q <= 1'b0;
    end else if (!lvl && run == LAST) begin
      lvl    <= 1'b1;
      rise_q <= 1'b1;
    end else begin
      rise_q <= 1'b0;
      if (!lvl) run <= run + 1'b1;
    end
  end

  assign ev.level = lvl;
  assign ev.rise  = rise_q;
endmodule

// File: rtl/fpg_delay_stage.sv
module fpg_delay_stage #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             level,
  input  logic             rise,
  input  logic [CNT_W-1:0] ticks,
  output logic             busy,
  output logic             fire
);
  logic [CNT_W-1:0] remain;
  logic             active;

  assign active = enable && level;
  // Fire on the expiry (falling side) of the delay, or at once for zero delay
  assign fire = active && ((rise && ticks == '0) || (busy && remain == CNT_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (!active) begin
      busy   <= 1'b0;
    end else if (rise) begin
      busy   <= (ticks != '0);
      remain <= ticks;
    end else if (busy) begin
      if (remain == CNT_W'(1)) busy <= 1'b0;
      else remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/fpg_pulse_stage.sv
module fpg_pulse_stage #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             level,
  input  logic             fire,
  input  logic [CNT_W-1:0] width,
  output logic             gate
);
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate <= 1'b0;
      left <= '0;
    end else if (!enable || !level) begin
      gate <= 1'b0;
    end else if (fire) begin
      gate <= 1'b1;
      left <= (width == '0) ? CNT_W'(1) : width;
    end else if (gate) begin
      if (left == CNT_W'(1)) gate <= 1'b0;
      else left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/firing_pulse_gen.sv
module firing_pulse_gen
  import fpg_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int HALF_CNT = 1000,
  parameter int FILT_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             sync_in,
  input  logic [CNT_W-1:0] angle,
  input  logic [CNT_W-1:0] width,
  output logic             gate,
  output logic             delay_busy
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HALF_CNT);

  sync_ev_t         ev;
  logic             lvl, rise, fire;
  logic [CNT_W-1:0] ticks;

  assign lvl   = ev.level;
  assign rise  = ev.rise;
  assign ticks = (angle > LIMIT) ? LIMIT : angle;

  fpg_sync_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst_n(rst_n), .raw(sync_in), .ev(ev)
  );

  fpg_delay_stage #(.CNT_W(CNT_W)) u_delay (
    .clk(clk), .rst_n(rst_n), .enable(enable), .level(lvl), .rise(rise),
    .ticks(ticks), .busy(delay_busy), .fire(fire)
  );

  fpg_pulse_stage #(.CNT_W(CNT_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .enable(enable), .level(lvl), .fire(fire),
    .width(width), .gate(gate)
  );
endmodule

// File: rtl/firing_pulse_gen_chk.sv
module firing_pulse_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic gate,
  input logic delay_busy,
  input logic lvl,
  input logic rise
);
  // R9: disabled block is idle one cycle later
  a_r9_enable_idles: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!gate && !delay_busy));

  // R7: gate is only held while the filtered level was high
  a_r7_gate_in_positive: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> $past(lvl));

  // R4: normal delay expiry launches the pulse
  a_r4_expiry_fires: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(delay_busy) && $past(lvl) && $past(enable) && lvl) |-> gate);

  // R8: a pulse only starts from a rising edge or a delay expiry
  a_r8_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> ($past(rise) || $fell(delay_busy)));

  // R4: delay and pulse never overlap
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate && delay_busy));
endmodule

bind firing_pulse_gen firing_pulse_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .gate(gate),
  .delay_busy(delay_busy), .lvl(lvl), .rise(rise)
);

// File: tb/firing_pulse_gen_test.sv
`timescale 1ns/1ps
module firing_pulse_gen_test;
  localparam int CNT_W = 16;
  localparam int HALF  = 1000;
  localparam int FL    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic sync_in = 1'b0;
  logic [CNT_W-1:0] angle = '0;
  logic [CNT_W-1:0] width = '0;
  logic gate, delay_busy;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  firing_pulse_gen #(.CNT_W(CNT_W), .HALF_CNT(HALF), .FILT_LEN(FL)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sync_in(sync_in),
    .angle(angle), .width(width), .gate(gate), .delay_busy(delay_busy)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  // Raise sync; return edges until gate high (count includes edge k as 1) and pulse length
  task automatic half_cycle(input int limit, output int lat, output int len);
    @(negedge clk);
    sync_in = 1'b1;
    lat = -1;
    len = 0;
    for (int i = 1; i <= limit; i++) begin
      @(posedge clk); #1;
      if (gate) begin lat = i; break; end
    end
    if (lat > 0) begin
      len = 1;
      for (int i = 0; i < 4000; i++) begin
        @(posedge clk); #1;
        if (!gate) break;
        len++;
      end
    end
  endtask

  task automatic low_phase();
    @(negedge clk);
    sync_in = 1'b0;
    tick(20);
  endtask

  task automatic t_reset();
    tick(3);
    check("R1 gate in reset", gate, 0);
    check("R1 busy in reset", delay_busy, 0);
    @(negedge clk); rst_n = 1'b1; enable = 1'b1;
    tick(1);
    check("R1 gate after reset", gate, 0);
    check("R1 busy after reset", delay_busy, 0);
  endtask

  task automatic t_zero_delay();
    int lat, len;
    angle = 0; width = 5;
    half_cycle(100, lat, len);
    check("R3 zero-delay latency", lat, FL + 3);
    check("R6 width 5", len, 5);
    low_phase();
  endtask

  task automatic t_delay_busy();
    int hi;
    angle = 12; width = 3;
    @(negedge clk); sync_in = 1'b1;
    tick(FL + 2);
    check("R4 busy before start", delay_busy, 0);
    hi = 0;
    for (int i = 0; i < 12; i++) begin
      tick(1);
      if (delay_busy && !gate) hi++;
    end
    check("R4 busy length", hi, 12);
    tick(1);
    check("R4 busy fell", delay_busy, 0);
    check("R4 gate rose with busy fall", gate, 1);
    low_phase();
  endtask

  task automatic t_delay_values();
    int lat, len;
    angle = 37; width = 8;
    half_cycle(200, lat, len);
    check("R4 delay 37 latency", lat, FL + 3 + 37);
    check("R6 width 8", len, 8);
    low_phase();
    angle = 1; width = 0;
    half_cycle(200, lat, len);
    check("R4 delay 1 latency", lat, FL + 4);
    check("R6 width 0 gives 1", len, 1);
    low_phase();
  endtask

  task automatic t_clamp();
    int lat, len;
    angle = 16'd5000; width = 2;
    half_cycle(3000, lat, len);
    check("R5 clamped latency", lat, FL + 3 + HALF);
    low_phase();
  endtask

  task automatic t_glitch();
    int seen;
    angle = 0; width = 4;
    @(negedge clk); sync_in = 1'b1;
    tick(FL - 1);
    @(negedge clk); sync_in = 1'b0;
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      tick(1);
      if (gate || delay_busy) seen++;
    end
    check("R2 short high rejected", seen, 0);
    tick(10);
  endtask

  task automatic t_cut_short();
    angle = 0; width = 500;
    @(negedge clk); sync_in = 1'b1;
    tick(FL + 3 + 20);
    check("R7 gate high before cut", gate, 1);
    @(negedge clk); sync_in = 1'b0;
    tick(4);
    check("R7 gate cut after sync low", gate, 0);
    tick(20);
  endtask

  task automatic t_angle_latch();
    int lat, len, extra;
    angle = 10; width = 3;
    @(negedge clk); sync_in = 1'b1;
    tick(FL + 3);
    @(negedge clk); angle = 30;
    lat = -1; extra = 0;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); #1;
      if (gate && lat < 0) lat = FL + 4 + i;
      if (!gate && lat > 0 && extra == 0 && i > 20) extra = -1;
    end
    check("R8 old angle used", lat, FL + 3 + 10);
    // Count rising edges of gate during the rest of the same high phase
    extra = 0;
    for (int i = 0; i < 100; i++) begin
      @(posedge clk); #1;
      if (gate) extra++;
    end
    check("R8 single pulse per half cycle", extra, 0);
    low_phase();
    half_cycle(200, lat, len);
    check("R8 new angle next cycle", lat, FL + 3 + 30);
    low_phase();
  endtask

  task automatic t_enable();
    int seen;
    angle = 50; width = 4;
    @(negedge clk); sync_in = 1'b1;
    tick(FL + 3 + 10);
    check("R9 busy before disable", delay_busy, 1);
    @(negedge clk); enable = 1'b0;
    tick(1);
    check("R9 busy cleared", delay_busy, 0);
    @(negedge clk); enable = 1'b1;
    seen = 0;
    for (int i = 0; i < 120; i++) begin
      tick(1);
      if (gate || delay_busy) seen++;
    end
    check("R9 no late pulse", seen, 0);
    low_phase();
  endtask

  task automatic t_abort();
    int seen;
    angle = 100; width = 4;
    @(negedge clk); sync_in = 1'b1;
    tick(FL + 3 + 30);
    @(negedge clk); sync_in = 1'b0;
    seen = 0;
    for (int i = 0; i < 150; i++) begin
      tick(1);
      if (gate) seen++;
    end
    check("R10 abandoned delay gives no pulse", seen, 0);
    check("R10 busy cleared", delay_busy, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_zero_delay();
    t_delay_busy();
    t_delay_values();
    t_clamp();
    t_glitch();
    t_cut_short();
    t_angle_latch();
    t_enable();
    t_abort();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule